// File: doc/BRIEF.md
# Hashed Load/Store Clash Matrix

This block flags possible memory conflicts between entries of a small load/store queue. When an entry is enqueued, a short hash of its address is computed once and kept in the entry's slot, together with a flag that says whether the entry is a load or a store. A triangular set of equality comparators then looks at every unordered pair of stored hashes. Each pair whose hashes match marks its two entries as possibly overlapping in memory.

The hash is an XOR fold of every address bit from bit 3 up to the top of the address, so page-number bits 12 to 21 take part in it. A match does not prove that the two entries overlap. The block is conservative: two identical addresses always match, and two different addresses with equal hashes also match. The scheduler that reads the matrix must treat a flagged pair as dependent. Up to four entries can be written in one cycle, and any set of entries can be retired in one cycle.

Top module: `lsq_clash_matrix`

## Requirements
- R1: While rst_n is low at a clock edge, every entry becomes invalid, so `clash_mtx` and `conflict` are all zero after that edge.
- R2: A port p with `enq_vld[p]=1` writes its hash and type into slot `enq_slot[p*3 +: 3]`, and that slot is valid from the next edge on. This holds whether the slot was free or occupied. `enq_store[p]` is 1 for a store and 0 for a load.
- R3: Hash bit k is the XOR of all address bits 3+i with i mod 16 = k, for i from 0 to 28. As a result, addresses that differ only in bit 21 do not match, while 0x20 and 0x200000 do match.
- R4: Bit `clash_mtx[i*8+j]` is 1 exactly when i≠j, both slots are valid, their hashes are equal and at least one of the two is a store.
- R5: Two loads never raise a clash, even when their addresses are identical.
- R6: The matrix is symmetric, and its diagonal is always zero.
- R7: `conflict[i]` is the OR of row i of the matrix.
- R8: `retire[i]=1` makes slot i invalid at the next edge, which clears row i and column i.
- R9: If a slot is retired and enqueued in the same cycle, the enqueue wins. If several ports target the same slot, the highest-numbered port wins.
- R10: A store and another entry at the same address always clash, and so do two addresses that differ only in bits 2:0.
- R11: Two different addresses with equal hashes are reported as a clash (an accepted false positive), for example 0x0 and 0x80008.
- R12: All four ports can enqueue to distinct slots in the same cycle, and every one of the writes takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_vld | input | 4 | Per-port enqueue strobe |
| enq_slot | input | 12 | Per-port target slot, 3 bits per port |
| enq_addr | input | 128 | Per-port address, 32 bits per port |
| enq_store | input | 4 | Per-port type, 1 = store |
| retire | input | 8 | Per-slot retire strobe |
| clash_mtx | output | 64 | Pair clash bits, index i*8+j |
| conflict | output | 8 | Per-slot OR of its row |

## Verification
The directed patterns each separate one distinction:
- identical addresses and addresses differing only below bit 3 show that the low bits are dropped;
- a load-load pair with identical addresses shows the type mask;
- the pair 0x0 and 0x80008, and the pair 0x20 and 0x200000, show the wrap of the fold;
- 0x0 against 0x200000 shows that the page bits take part in the hash;
- a retire that meets an enqueue in the same cycle, and two ports aimed at one slot, show the write priority.

After the directed patterns, a long random phase draws addresses from a narrow bit mask so that hashes collide often. Every clock, a behavioural queue model is compared with the full matrix and the summary vector.

// File: rtl/lsq_clash_pkg.sv
// Package: shared constants and the entry type code for the clash matrix.
// Assumes: nothing beyond IEEE 1800-2017.
package lsq_clash_pkg;
    localparam int DEF_ENTRIES = 8;
    localparam int DEF_PORTS   = 4;
    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_HASH_W  = 16;
    localparam int DEF_LO_BIT  = 3;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_kind_e;
endpackage

// File: rtl/lsq_hash_fold.sv
// Module: XOR-folds address bits LO_BIT and above into a HASH_W-bit hash.
// Assumes: ADDR_W > LO_BIT; purely combinational.
module lsq_hash_fold #(
    parameter int ADDR_W = 32,
    parameter int HASH_W = 16,
    parameter int LO_BIT = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [HASH_W-1:0] hash
);
    localparam int SPAN = ADDR_W - LO_BIT;

    // Fold: each address bit above LO_BIT toggles hash bit (offset mod HASH_W).
    always_comb begin
        hash = '0;
        for (int i = 0; i < SPAN; i++) begin
            hash[i % HASH_W] = hash[i % HASH_W] ^ addr[LO_BIT + i];
        end
    end
endmodule

// File: rtl/lsq_entry_store.sv
// Module: per-slot registers holding valid, stored hash and op type.
// Assumes: enqueue beats retire on the same slot; the highest port wins a
// slot that several ports target.
module lsq_entry_store
    import lsq_clash_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int PORTS       = 4,
    parameter int HASH_W      = 16,
    parameter int SLOT_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PORTS-1:0]        wr_en,
    input  logic [PORTS*SLOT_W-1:0] wr_slot,
    input  logic [HASH_W-1:0]       wr_hash [PORTS],
    input  logic [PORTS-1:0]        wr_store,
    input  logic [NUM_ENTRIES-1:0]  retire,
    output logic [NUM_ENTRIES-1:0]  ent_vld,
    output logic [NUM_ENTRIES-1:0]  ent_st,
    output logic [HASH_W-1:0]       ent_hash [NUM_ENTRIES]
);
    // Update: retire first, then enqueues in ascending port order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_st  <= '0;
            for (int e = 0; e < NUM_ENTRIES; e++) ent_hash[e] <= '0;
        end else begin
            ent_vld <= ent_vld & ~retire;
            for (int p = 0; p < PORTS; p++) begin
                if (wr_en[p]) begin
                    ent_vld[wr_slot[p*SLOT_W +: SLOT_W]]  <= 1'b1;
                    ent_st[wr_slot[p*SLOT_W +: SLOT_W]]   <= wr_store[p];
                    ent_hash[wr_slot[p*SLOT_W +: SLOT_W]] <= wr_hash[p];
                end
            end
        end
    end
endmodule

// File: rtl/lsq_pair_cmp.sv
// Module: one pair comparator. It raises hit on a hash match between two
// valid entries when at least one of them is a store.
// Assumes: inputs come from registers; purely combinational.
module lsq_pair_cmp #(
    parameter int HASH_W = 16
) (
    input  logic [HASH_W-1:0] hash_a,
    input  logic [HASH_W-1:0] hash_b,
    input  logic              vld_a,
    input  logic              vld_b,
    input  logic              st_a,
    input  logic              st_b,
    output logic              hit
);
    logic [HASH_W-1:0] diff;
    logic              same;

    // Compare: XOR per bit, then a NOR reduction to one match bit.
    always_comb begin
        diff = hash_a ^ hash_b;
        same = ~(|diff);
        hit  = same & vld_a & vld_b & (st_a | st_b);
    end
endmodule

// File: rtl/lsq_clash_matrix.sv
// Module: top of the hashed clash matrix. It hashes each enqueued address
// once, stores the hash per slot, and compares only the unique pairs.
// Assumes: synchronous active-low reset; outputs are combinational from
// the slot registers.
module lsq_clash_matrix
    import lsq_clash_pkg::*;
#(
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    parameter int PORTS       = DEF_PORTS,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int HASH_W      = DEF_HASH_W,
    parameter int LO_BIT      = DEF_LO_BIT,
    parameter int SLOT_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PORTS-1:0]              enq_vld,
    input  logic [PORTS*SLOT_W-1:0]       enq_slot,
    input  logic [PORTS*ADDR_W-1:0]       enq_addr,
    input  logic [PORTS-1:0]              enq_store,
    input  logic [NUM_ENTRIES-1:0]        retire,
    output logic [NUM_ENTRIES*NUM_ENTRIES-1:0] clash_mtx,
    output logic [NUM_ENTRIES-1:0]        conflict
);
    logic [HASH_W-1:0]      enq_hash [PORTS];
    logic [NUM_ENTRIES-1:0] ent_vld;
    logic [NUM_ENTRIES-1:0] ent_st;
    logic [HASH_W-1:0]      ent_hash [NUM_ENTRIES];
    logic                   pair_hit [NUM_ENTRIES][NUM_ENTRIES];

    // One hash unit per enqueue port.
    for (genvar p = 0; p < PORTS; p++) begin : g_hash
        lsq_hash_fold #(
            .ADDR_W (ADDR_W),
            .HASH_W (HASH_W),
            .LO_BIT (LO_BIT)
        ) u_fold (
            .addr (enq_addr[p*ADDR_W +: ADDR_W]),
            .hash (enq_hash[p])
        );
    end

    lsq_entry_store #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .PORTS       (PORTS),
        .HASH_W      (HASH_W),
        .SLOT_W      (SLOT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (enq_vld),
        .wr_slot  (enq_slot),
        .wr_hash  (enq_hash),
        .wr_store (enq_store),
        .retire   (retire),
        .ent_vld  (ent_vld),
        .ent_st   (ent_st),
        .ent_hash (ent_hash)
    );

    // Upper triangle has comparators, lower triangle mirrors, diagonal is 0.
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_row
        for (genvar j = 0; j < NUM_ENTRIES; j++) begin : g_col
            if (j > i) begin : g_cmp
                lsq_pair_cmp #(.HASH_W(HASH_W)) u_cmp (
                    .hash_a (ent_hash[i]),
                    .hash_b (ent_hash[j]),
                    .vld_a  (ent_vld[i]),
                    .vld_b  (ent_vld[j]),
                    .st_a   (ent_st[i]),
                    .st_b   (ent_st[j]),
                    .hit    (pair_hit[i][j])
                );
            end else if (j < i) begin : g_mirror
                assign pair_hit[i][j] = pair_hit[j][i];
            end else begin : g_diag
                assign pair_hit[i][j] = 1'b0;
            end
        end
    end

    // Flatten the matrix and OR each row into the summary.
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            conflict[i] = 1'b0;
            for (int j = 0; j < NUM_ENTRIES; j++) begin
                clash_mtx[i*NUM_ENTRIES + j] = pair_hit[i][j];
                conflict[i] = conflict[i] | pair_hit[i][j];
            end
        end
    end
endmodule

// File: rtl/lsq_clash_checker.sv
// Module: assertions for lsq_clash_matrix, attached with bind.
// Assumes: it sees the slot valid and type registers through the bind.
module lsq_clash_checker #(
    parameter int NUM_ENTRIES = 8,
    parameter int PORTS       = 4,
    parameter int SLOT_W      = 3
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [PORTS-1:0]                   enq_vld,
    input logic [PORTS*SLOT_W-1:0]            enq_slot,
    input logic [NUM_ENTRIES-1:0]             retire,
    input logic [NUM_ENTRIES-1:0]             ent_vld,
    input logic [NUM_ENTRIES-1:0]             ent_st,
    input logic [NUM_ENTRIES*NUM_ENTRIES-1:0] clash_mtx,
    input logic [NUM_ENTRIES-1:0]             conflict
);
    logic [NUM_ENTRIES-1:0] enq_hit;

    // Decode: which slots some port writes this cycle.
    always_comb begin
        enq_hit = '0;
        for (int p = 0; p < PORTS; p++)
            if (enq_vld[p]) enq_hit[enq_slot[p*SLOT_W +: SLOT_W]] = 1'b1;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (conflict == '0)) else $error("reset"); // R1

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_i
        AST_DIAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !clash_mtx[i*NUM_ENTRIES + i]) else $error("diag"); // R6
        AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (retire[i] && !enq_hit[i]) |=> (clash_mtx[i*NUM_ENTRIES +: NUM_ENTRIES] == '0))
            else $error("retire"); // R8
        AST_ENQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            enq_hit[i] |=> ent_vld[i]) else $error("enq"); // R2
        for (genvar j = 0; j < NUM_ENTRIES; j++) begin : g_j
            if (j != i) begin : g_pair
                AST_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
                    clash_mtx[i*NUM_ENTRIES + j] == clash_mtx[j*NUM_ENTRIES + i])
                    else $error("sym"); // R6
                AST_NO_LOAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
                    clash_mtx[i*NUM_ENTRIES + j] |-> (ent_st[i] || ent_st[j]))
                    else $error("ldld"); // R5
                AST_BOTH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                    clash_mtx[i*NUM_ENTRIES + j] |-> (ent_vld[i] && ent_vld[j]))
                    else $error("vld"); // R4
            end
        end
    end
endmodule

bind lsq_clash_matrix lsq_clash_checker #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .PORTS       (PORTS),
    .SLOT_W      (SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_vld   (enq_vld),
    .enq_slot  (enq_slot),
    .retire    (retire),
    .ent_vld   (ent_vld),
    .ent_st    (ent_st),
    .clash_mtx (clash_mtx),
    .conflict  (conflict)
);

// File: tb/lsq_clash_matrix_test.sv
// Bench: behavioural queue model compared with the outputs on every clock,
// plus directed checks with hand-derived expectations.
module lsq_clash_matrix_test;
    localparam int N = 8;
    localparam int P = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [P-1:0]  enq_vld = '0;
    logic [P*3-1:0]  enq_slot = '0;
    logic [P*32-1:0] enq_addr = '0;
    logic [P-1:0]  enq_store = '0;
    logic [N-1:0]  retire = '0;
    logic [N*N-1:0] clash_mtx;
    logic [N-1:0]  conflict;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit cmp_on = 0;
    string cur_req = "R4";

    bit          m_v [N];
    bit          m_s [N];
    int unsigned m_h [N];

    always #2 clk = ~clk;

    lsq_clash_matrix uut (
        .clk (clk), .rst_n (rst_n), .enq_vld (enq_vld), .enq_slot (enq_slot),
        .enq_addr (enq_addr), .enq_store (enq_store), .retire (retire),
        .clash_mtx (clash_mtx), .conflict (conflict)
    );

    // Hash from R3: address bit b (b >= 3) toggles hash bit (b-3) mod 16.
    function automatic int unsigned ref_hash(input logic [31:0] a);
        int unsigned h = 0;
        for (int b = 3; b < 32; b++)
            if (a[b]) h = h ^ (32'd1 << ((b - 3) % 16));
        return h;
    endfunction

    // Model update at the edge: reset, retire, then enqueues by port order.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) m_v[e] = 0;
        end else begin
            for (int e = 0; e < N; e++) if (retire[e]) m_v[e] = 0;
            for (int p = 0; p < P; p++) begin
                if (enq_vld[p]) begin
                    m_v[enq_slot[p*3 +: 3]] = 1;
                    m_s[enq_slot[p*3 +: 3]] = enq_store[p];
                    m_h[enq_slot[p*3 +: 3]] = ref_hash(enq_addr[p*32 +: 32]);
                end
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of the full matrix and summary against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [N*N-1:0] em;
            logic [N-1:0]   es;
            em = '0; es = '0;
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (i != j && m_v[i] && m_v[j] && m_h[i] == m_h[j] && (m_s[i] || m_s[j])) begin
                        em[i*N + j] = 1'b1;
                        es[i] = 1'b1;
                    end
            check(cur_req, "matrix", 64'(clash_mtx), 64'(em));
            check("R7", "summary", 64'(conflict), 64'(es));
        end
    end

    task automatic idle();
        enq_vld = '0; retire = '0; enq_store = '0; enq_slot = '0; enq_addr = '0;
    endtask

    task automatic put(input int p, input int slot, input logic [31:0] a, input bit st);
        enq_vld[p] = 1'b1;
        enq_slot[p*3 +: 3] = 3'(slot);
        enq_addr[p*32 +: 32] = a;
        enq_store[p] = st;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R1", "reset matrix", 64'(clash_mtx), 64'd0);
        check("R1", "reset summary", 64'(conflict), 64'd0);
        #1 rst_n = 1'b1;
        cmp_on = 1;

        // R12, R2, R10, R5: four enqueues at once.
        cur_req = "R12";
        put(0, 0, 32'h1000, 1); put(1, 1, 32'h1004, 0);
        put(2, 2, 32'h1000, 0); put(3, 3, 32'h0, 1);
        @(negedge clk);
        check("R10", "st/ld low-bit diff", 64'(clash_mtx[0*N+1]), 64'd1);
        check("R6", "mirror", 64'(clash_mtx[1*N+0]), 64'd1);
        check("R5", "load-load same addr", 64'(clash_mtx[1*N+2]), 64'd0);
        check("R10", "store/load same addr", 64'(clash_mtx[0*N+2]), 64'd1);
        #1 idle();

        // R11 and R3: fold wrap collisions and page-bit separation.
        cur_req = "R3";
        put(0, 4, 32'h0008_0008, 0); put(1, 5, 32'h0020_0000, 1);
        put(2, 6, 32'h0000_0020, 0);
        @(negedge clk);
        check("R11", "false positive 0/80008", 64'(clash_mtx[3*N+4]), 64'd1);
        check("R3", "bit21 vs bit5 fold", 64'(clash_mtx[5*N+6]), 64'd1);
        check("R3", "bit21 separates", 64'(clash_mtx[3*N+5]), 64'd0);
        #1 idle();

        // R8: retire slot 0.
        cur_req = "R8";
        retire[0] = 1'b1;
        @(negedge clk);
        check("R8", "row0 cleared", 64'(clash_mtx[0*N +: N]), 64'd0);
        check("R8", "slot2 summary", 64'(conflict[2]), 64'd0);
        check("R8", "slot1 summary", 64'(conflict[1]), 64'd0);
        #1 idle();

        // R9: enqueue beats retire; highest port wins a shared slot.
        cur_req = "R9";
        retire[3] = 1'b1; put(0, 3, 32'h0008_0008, 1);
        put(1, 7, 32'h1000, 1); put(2, 7, 32'h5000, 0);
        @(negedge clk);
        check("R9", "enq beats retire", 64'(conflict[3]), 64'd1);
        check("R9", "high port wins", 64'(conflict[7]), 64'd0);
        #1 idle();

        // Random phase with a narrow address mask to provoke collisions.
        cur_req = "R4";
        for (int c = 0; c < 400; c++) begin
            for (int p = 0; p < P; p++)
                if ($urandom_range(0, 2) == 0)
                    put(p, int'($urandom_range(0, N-1)), $urandom & 32'h0028_1028, bit'($urandom_range(0, 1)));
            retire = N'($urandom) & N'($urandom);
            @(negedge clk);
            #1 idle();
        end
        @(negedge clk);
        cmp_on = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule